// File: doc/BRIEF.md
# Multi-channel reloadable interval timer

A bank of independent counting channels behind a single word-addressed register port. Every channel has a control/status word, a load word, a counter that can only be read, and a spare word. All channels advance from one common tick-enable input. Each channel counts up or down from its load value. When it reaches its terminal count it sets a status flag, and then it either stops or reloads and keeps going.

Software starts a channel by writing the control word with the enable bit set. This copies the load word into the counter. Any write to the control word clears the channel's flag. One level interrupt line is shared by every channel: it is high while any channel has both its flag and its interrupt-enable bit set.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register of every channel reads 0, every channel is stopped and `irq` is low.
- R2: The word address is {channel, slot}. The slots are 0 = control, 1 = load, 2 = counter and 3 = spare. A read returns the addressed word on `rdata` one cycle after `rd_en`. The load and spare slots read back the last value written to that channel, and each channel holds its own copy.
- R3: The counter slot reads back the current count in both directions. Writes to the counter slot have no effect.
- R4: A write to the control slot stores the written value with bit 8 (the flag) forced to 0, so the write clears a pending flag.
- R5: A control write with bit 7 set copies the load word into the counter and starts the channel, even if it is already running. A control write with bit 7 clear stops the channel and the count holds.
- R6: A running channel changes its count only in cycles where `tick` is high. Control bit 1 set means it counts down by 1; bit 1 clear means it counts up by 1.
- R7: Expiry is a tick while the count is 0 in down mode, or a tick while the count is all ones in up mode. Expiry sets control bit 8.
- R8: On expiry with control bit 4 clear, the channel stops and its count stays at the terminal value. With bit 4 set, the count is reloaded from the load word and the channel keeps running.
- R9: `irq` is high one cycle after any channel has both bit 8 and bit 6 (interrupt enable) set, and low one cycle after no channel does.
- R10: When a control write to a channel coincides with that channel's expiry, the write decides the flag and the run state: the flag ends at 0 and the channel does not reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word address {channel, slot} |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| irq | output | 1 | Shared level interrupt |

## Verification
A wrong count, direction or reload shows up on the next counter-slot read, one cycle after `rd_en`. A flag that is not set, or not cleared, shows on the control read and on `irq` within two cycles of the tick or write that should have changed it. A channel that fails to stop or start is caught by reading its counter again after further ticks. A miswired channel select is caught by giving each channel distinct load values.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int CSR_DOWN = 1;
  localparam int CSR_ARL  = 4;
  localparam int CSR_IEN  = 6;
  localparam int CSR_RUN  = 7;
  localparam int CSR_FLAG = 8;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_LOAD  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_SPARE = 2'd3
  } slot_e;
endpackage

// File: rtl/tt_channel.sv
module tt_channel import tt_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_we,
  input  logic          load_we,
  input  logic          spare_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] load,
  output logic [DW-1:0] spare,
  output logic [DW-1:0] count,
  output logic          running
);
  logic at_end;

  always_comb begin
    if (ctrl[CSR_DOWN]) at_end = (count == '0);
    else                at_end = (count == '1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      load    <= '0;
      spare   <= '0;
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (load_we)  load  <= wdata;
      if (spare_we) spare <= wdata;
      if (ctrl_we) begin
        ctrl           <= wdata;
        ctrl[CSR_FLAG] <= 1'b0;
        running        <= wdata[CSR_RUN];
        if (wdata[CSR_RUN]) count <= load;
      end else if (running && tick) begin
        if (at_end) begin
          ctrl[CSR_FLAG] <= 1'b1;
          if (ctrl[CSR_ARL]) count <= load;
          else               running <= 1'b0;
        end else if (ctrl[CSR_DOWN]) begin
          count <= count - 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tt_rdmux.sv
module tt_rdmux import tt_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [CW-1:0] sel,
  input  logic [1:0]    slot,
  input  logic [DW-1:0] ctrl_a  [NCH],
  input  logic [DW-1:0] load_a  [NCH],
  input  logic [DW-1:0] spare_a [NCH],
  input  logic [DW-1:0] count_a [NCH],
  output logic [DW-1:0] rdata
);
  logic          in_range;
  logic [DW-1:0] word;

  always_comb begin
    in_range = (int'(sel) < NCH);
    word     = '0;
    if (in_range) begin
      case (slot_e'(slot))
        SLOT_CTRL:  word = ctrl_a[sel];
        SLOT_LOAD:  word = load_a[sel];
        SLOT_COUNT: word = count_a[sel];
        default:    word = spare_a[sel];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank import tt_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [CW-1:0]  sel;
  logic [1:0]     slot;
  logic [DW-1:0]  ctrl_a  [NCH];
  logic [DW-1:0]  load_a  [NCH];
  logic [DW-1:0]  spare_a [NCH];
  logic [DW-1:0]  count_a [NCH];
  logic [NCH-1:0] run_vec;
  logic [NCH-1:0] flag_vec;
  logic [NCH-1:0] ien_vec;
  logic [NCH-1:0] ctrl_we_vec;

  assign sel  = addr[AW-1:2];
  assign slot = addr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit            = wr_en && (int'(sel) == g);
    assign ctrl_we_vec[g] = hit && (slot == SLOT_CTRL);
    assign flag_vec[g]    = ctrl_a[g][CSR_FLAG];
    assign ien_vec[g]     = ctrl_a[g][CSR_IEN];

    tt_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .ctrl_we  (ctrl_we_vec[g]),
      .load_we  (hit && (slot == SLOT_LOAD)),
      .spare_we (hit && (slot == SLOT_SPARE)),
      .wdata    (wdata),
      .ctrl     (ctrl_a[g]),
      .load     (load_a[g]),
      .spare    (spare_a[g]),
      .count    (count_a[g]),
      .running  (run_vec[g])
    );
  end

  tt_rdmux #(.NCH(NCH), .DW(DW), .CW(CW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .sel     (sel),
    .slot    (slot),
    .ctrl_a  (ctrl_a),
    .load_a  (load_a),
    .spare_a (spare_a),
    .count_a (count_a),
    .rdata   (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_vec & ien_vec);
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker import tt_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           irq,
  input logic [DW-1:0]  wdata,
  input logic [NCH-1:0] ctrl_we_vec,
  input logic [NCH-1:0] run_vec,
  input logic [NCH-1:0] flag_vec,
  input logic [NCH-1:0] ien_vec,
  input logic [DW-1:0]  ctrl_a  [NCH],
  input logic [DW-1:0]  load_a  [NCH],
  input logic [DW-1:0]  count_a [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_we_vec[g] |=> !flag_vec[g]);
    // R5
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_we_vec[g] && wdata[CSR_RUN] |=> run_vec[g] && (count_a[g] == $past(load_a[g])));
    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
      !tick && !ctrl_we_vec[g] |=> $stable(count_a[g]));
    // R8
    stop_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
      run_vec[g] && tick && !ctrl_we_vec[g] && ctrl_a[g][CSR_DOWN] && !ctrl_a[g][CSR_ARL]
      && (count_a[g] == '0) |=> !run_vec[g] && flag_vec[g]);
  end

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_vec & ien_vec) == '0) |=> !irq);
  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_vec & ien_vec) != '0) |=> irq);
endmodule

bind tick_timer_bank tt_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .irq         (irq),
  .wdata       (wdata),
  .ctrl_we_vec (ctrl_we_vec),
  .run_vec     (run_vec),
  .flag_vec    (flag_vec),
  .ien_vec     (ien_vec),
  .ctrl_a      (ctrl_a),
  .load_a      (load_a),
  .count_a     (count_a)
);

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  tick_timer_bank #(.NCH(NCH), .DW(DW)) u_tick_timer_bank (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compares each read response with the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input int ch, input int sl, input logic [DW-1:0] d, input logic tk = 1'b0);
    wr_en = 1'b1; addr = AW'(ch * 4 + sl); wdata = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input int ch, input int sl, input logic [DW-1:0] e, input string t);
    rd_en = 1'b1; addr = AW'(ch * 4 + sl);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(0, 0, 0, "R1"); rd(0, 1, 0, "R1"); rd(0, 2, 0, "R1"); rd(3, 2, 0, "R1");
    chk_irq(1'b0, "R1");
    // R2 load/spare storage per channel
    wr(0, 1, 5); wr(0, 3, 32'hABCD); wr(1, 1, 32'h77);
    rd(0, 1, 5, "R2"); rd(0, 3, 32'hABCD, "R2"); rd(1, 1, 32'h77, "R2"); rd(2, 1, 0, "R2");
    // R3 counter slot write ignored
    wr(0, 2, 32'h1234); rd(0, 2, 0, "R3");
    // R5 / R6 down counting
    wr(0, 0, 32'h82); rd(0, 2, 5, "R5");
    ticks(3); rd(0, 2, 2, "R6");
    // R7 / R8 expiry without reload
    ticks(3);
    rd(0, 0, 32'h182, "R7"); rd(0, 2, 0, "R8");
    ticks(4); rd(0, 2, 0, "R8");
    chk_irq(1'b0, "R9");
    // R4 flag cleared, R5 restart while running, R6 no tick no change
    wr(0, 0, 32'h82); rd(0, 0, 32'h82, "R4");
    ticks(2); idle(5); rd(0, 2, 3, "R6");
    wr(0, 0, 32'h82); rd(0, 2, 5, "R5");
    wr(0, 0, 32'h02); ticks(2); rd(0, 2, 5, "R5");
    // R9 interrupt raise and clear
    wr(0, 0, 32'hC2); ticks(6); idle(1);
    chk_irq(1'b1, "R9");
    wr(0, 0, 32'h42); idle(1);
    chk_irq(1'b0, "R4");
    wr(1, 0, 32'h100); rd(1, 0, 0, "R4");
    // R8 down reload
    wr(1, 1, 2); wr(1, 0, 32'h92); ticks(3);
    rd(1, 2, 2, "R8"); rd(1, 0, 32'h192, "R8");
    ticks(1); rd(1, 2, 1, "R8");
    chk_irq(1'b0, "R9");
    // R7 up mode expiry and stop
    wr(2, 1, 32'hFFFF_FFFD); wr(2, 0, 32'hC0); ticks(2);
    rd(2, 2, 32'hFFFF_FFFF, "R6"); rd(2, 0, 32'hC0, "R7");
    ticks(1); rd(2, 0, 32'h1C0, "R7");
    ticks(2); rd(2, 2, 32'hFFFF_FFFF, "R8");
    chk_irq(1'b1, "R9");
    // R8 up reload
    wr(3, 1, 32'hFFFF_FFFE); wr(3, 0, 32'h90); ticks(2);
    rd(3, 2, 32'hFFFF_FFFE, "R8");
    ticks(1); rd(3, 2, 32'hFFFF_FFFF, "R6");
    wr(2, 0, 32'h40); idle(1);
    chk_irq(1'b0, "R9");
    // R10 write coincides with expiry
    wr(0, 1, 1); wr(0, 0, 32'h92); ticks(1);
    wr(0, 0, 32'h40, 1'b1);
    rd(0, 0, 32'h40, "R10"); rd(0, 2, 0, "R10");
    idle(1);
    chk_irq(1'b0, "R10");
    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule